// File: doc/BRIEF.md
# Lane Drive Level Validator

This block screens a requested transmit link setup before it is applied to the analog lanes. It takes a lane count, a rate selector, two request flags (rate change and drive level change) and, per lane, a 2-bit voltage swing level and a 2-bit pre-emphasis level. It decides whether the whole request is legal and turns each active lane's level pair into three analog drive codes: amplitude, amplitude scale and emphasis.

The legal level pairs form a triangle: swing plus pre-emphasis may not exceed 3. Each legal cell maps to a fixed code triple that does not follow a linear rule, so the block holds a small lookup. A one-cycle `start` pulse samples the request. One clock later `done` pulses, `err` reports the verdict, and the per-lane codes are presented. All of these outputs hold until the next `start`. Writing the codes into the analog control registers is left to the surrounding logic.

Top module: `drive_level_checker`

## Requirements
- R1: A `start` sampled high at a clock edge produces `done` high for exactly the following cycle, and only then. `err` and all codes update only on a `start` and hold their values otherwise.
- R2: The lane count is legal only for the values 1, 2 or 4. Any other value sets `err`.
- R3: When `set_rate` is high, `rate_sel` 0 (1.62 Gb/s) and 1 (2.7 Gb/s) are legal and 2 or 3 set `err`. When `set_rate` is low, `rate_sel` has no effect.
- R4: When `set_lvl` is high, an active lane (index below the lane count) whose swing plus pre-emphasis exceeds 3 sets `err`. Lanes at or above the lane count are not checked.
- R5: At swing 0, pre-emphasis 0, 1, 2, 3 give amplitude codes 1, 2, 3, 5 and emphasis codes 0x0, 0x4, 0x8, 0xF.
- R6: At swing 1, pre-emphasis 0, 1, 2 give amplitude codes 3, 5, 6 and emphasis codes 0x0, 0x7, 0x6.
- R7: At swing 2, pre-emphasis 0 and 1 give amplitude codes 5 and 7 with emphasis 0x0 and 0x4. Swing 3 with pre-emphasis 0 gives amplitude 7 and emphasis 0x0.
- R8: On an accepted request with `set_lvl` high, each active lane's amplitude scale code is 1.
- R9: Lanes at or above the lane count, and all lanes when `set_lvl` is low, output zero codes.
- R10: While `err` is high, every amplitude, scale and emphasis code is zero.
- R11: After reset, `done` and `err` are low and every code is zero.

Lane i uses bits [2i+1:2i] of `swing` and `preemph`, bits [3i+2:3i] of `amp`, bits [2i+1:2i] of `amp_scale` and bits [4i+3:4i] of `emph`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Samples the request |
| lane_cnt | input | 3 | Requested number of lanes |
| rate_sel | input | 2 | Rate selector: 0 is 1.62 Gb/s, 1 is 2.7 Gb/s |
| set_rate | input | 1 | Rate change requested |
| set_lvl | input | 1 | Drive level change requested |
| swing | input | 8 | Per-lane 2-bit swing level |
| preemph | input | 8 | Per-lane 2-bit pre-emphasis level |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Request rejected |
| amp | output | 12 | Per-lane 3-bit amplitude code |
| amp_scale | output | 8 | Per-lane 2-bit amplitude scale code |
| emph | output | 16 | Per-lane 4-bit emphasis code |

## Verification
The assertions check on every cycle that `done` follows `start` by one clock and appears at no other time. They also check that outputs hold between requests, that an error forces all codes to zero, and that illegal counts, illegal rates and an over-range lane 0 pair are rejected. Only the bench scenarios can show the exact code triple for each of the ten legal cells, the masking of lanes above the count, and that an out-of-range pair on an inactive lane is ignored. The scoreboard compares every field against a model built from the level table.

// File: rtl/drive_level_checker.sv
module drive_level_checker #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CW-1:0]      lane_cnt,
  input  logic [1:0]         rate_sel,
  input  logic               set_rate,
  input  logic               set_lvl,
  input  logic [LANES*2-1:0] swing,
  input  logic [LANES*2-1:0] preemph,
  output logic               done,
  output logic               err,
  output logic [LANES*3-1:0] amp,
  output logic [LANES*2-1:0] amp_scale,
  output logic [LANES*4-1:0] emph
);
  localparam int AW = 3;
  localparam int SW = 2;
  localparam int EW = 4;

  function automatic logic [AW+EW-1:0] level_lut(input logic [1:0] s, input logic [1:0] p);
    case ({s, p})
      4'h0:    level_lut = {3'd1, 4'h0};
      4'h1:    level_lut = {3'd2, 4'h4};
      4'h2:    level_lut = {3'd3, 4'h8};
      4'h3:    level_lut = {3'd5, 4'hf};
      4'h4:    level_lut = {3'd3, 4'h0};
      4'h5:    level_lut = {3'd5, 4'h7};
      4'h6:    level_lut = {3'd6, 4'h6};
      4'h8:    level_lut = {3'd5, 4'h0};
      4'h9:    level_lut = {3'd7, 4'h4};
      4'hc:    level_lut = {3'd7, 4'h0};
      default: level_lut = '0;
    endcase
  endfunction

  logic             cnt_ok, rate_ok, any_err;
  logic [LANES-1:0] lane_on, lane_bad;
  logic [LANES*AW-1:0] amp_d;
  logic [LANES*SW-1:0] scl_d;
  logic [LANES*EW-1:0] emp_d;

  assign cnt_ok  = (lane_cnt == CW'(1) || lane_cnt == CW'(2) || lane_cnt == CW'(4))
                   && (lane_cnt <= CW'(LANES));
  assign rate_ok = !set_rate || (rate_sel == 2'd0) || (rate_sel == 2'd1);
  assign any_err = !cnt_ok || !rate_ok || (|lane_bad);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [2:0]       lvl_sum;
    logic [AW+EW-1:0] code;
    assign lane_on[i]  = CW'(i) < lane_cnt;
    assign lvl_sum     = {1'b0, swing[2*i+:2]} + {1'b0, preemph[2*i+:2]};
    assign lane_bad[i] = set_lvl && lane_on[i] && (lvl_sum > 3'd3);
    assign code        = level_lut(swing[2*i+:2], preemph[2*i+:2]);
    always_comb begin
      if (set_lvl && lane_on[i] && !any_err) begin
        amp_d[AW*i+:AW] = code[AW+EW-1:EW];
        scl_d[SW*i+:SW] = SW'(1);
        emp_d[EW*i+:EW] = code[EW-1:0];
      end else begin
        amp_d[AW*i+:AW] = '0;
        scl_d[SW*i+:SW] = '0;
        emp_d[EW*i+:EW] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      err       <= 1'b0;
      amp       <= '0;
      amp_scale <= '0;
      emph      <= '0;
    end else begin
      done <= start;
      if (start) begin
        err       <= any_err;
        amp       <= amp_d;
        amp_scale <= scl_d;
        emph      <= emp_d;
      end
    end
  end
endmodule

module drive_level_checker_sva #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CW-1:0]      lane_cnt,
  input logic [1:0]         rate_sel,
  input logic               set_rate,
  input logic               set_lvl,
  input logic [LANES*2-1:0] swing,
  input logic [LANES*2-1:0] preemph,
  input logic               done,
  input logic               err,
  input logic [LANES*3-1:0] amp,
  input logic [LANES*2-1:0] amp_scale,
  input logic [LANES*4-1:0] emph
);
  logic       cnt_legal;
  logic [2:0] sum0;
  assign cnt_legal = lane_cnt == CW'(1) || lane_cnt == CW'(2) || lane_cnt == CW'(4);
  assign sum0      = {1'b0, swing[1:0]} + {1'b0, preemph[1:0]};

  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
  a_r1_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(err) && $stable(amp) && $stable(amp_scale) && $stable(emph));
  a_r2_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cnt_legal |=> err);
  a_r3_bad_rate: assert property (@(posedge clk) disable iff (!rst_n)
    start && set_rate && rate_sel[1] |=> err);
  a_r4_lane0_range: assert property (@(posedge clk) disable iff (!rst_n)
    start && set_lvl && sum0 > 3'd3 |=> err);
  a_r8_scale_one: assert property (@(posedge clk) disable iff (!rst_n)
    start && set_lvl |=> err || amp_scale[1:0] == 2'd1);
  a_r9_no_levels: assert property (@(posedge clk) disable iff (!rst_n)
    start && !set_lvl |=> amp == '0 && amp_scale == '0 && emph == '0);
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> amp == '0 && amp_scale == '0 && emph == '0);
endmodule

bind drive_level_checker drive_level_checker_sva #(.LANES(LANES), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt), .rate_sel(rate_sel),
  .set_rate(set_rate), .set_lvl(set_lvl), .swing(swing), .preemph(preemph),
  .done(done), .err(err), .amp(amp), .amp_scale(amp_scale), .emph(emph));

// File: tb/drive_level_checker_bench.sv
`timescale 1ns/1ps
module drive_level_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  lane_cnt = '0;
  logic [1:0]  rate_sel = '0;
  logic        set_rate = 1'b0;
  logic        set_lvl = 1'b0;
  logic [7:0]  swing = '0;
  logic [7:0]  preemph = '0;
  logic        done, err;
  logic [11:0] amp;
  logic [7:0]  amp_scale;
  logic [15:0] emph;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    logic        err;
    logic [11:0] amp;
    logic [7:0]  scl;
    logic [15:0] emp;
  } exp_t;
  exp_t q[$];
  exp_t last;

  always #4 clk = ~clk;

  drive_level_checker u_drive_level_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt), .rate_sel(rate_sel),
    .set_rate(set_rate), .set_lvl(set_lvl), .swing(swing), .preemph(preemph),
    .done(done), .err(err), .amp(amp), .amp_scale(amp_scale), .emph(emph));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic void lut(int s, int p, output int a, output int e);
    a = 0; e = 0;
    case (s * 4 + p)
      0: begin a = 1; e = 0;  end
      1: begin a = 2; e = 4;  end
      2: begin a = 3; e = 8;  end
      3: begin a = 5; e = 15; end
      4: begin a = 3; e = 0;  end
      5: begin a = 5; e = 7;  end
      6: begin a = 6; e = 6;  end
      8: begin a = 5; e = 0;  end
      9: begin a = 7; e = 4;  end
      12: begin a = 7; e = 0; end
      default: ;
    endcase
  endfunction

  task automatic go(string tag, int lc, int rc, bit sr, bit sv, logic [7:0] sw, logic [7:0] pe);
    exp_t x;
    int a, e;
    @(negedge clk);
    lane_cnt = 3'(lc); rate_sel = 2'(rc); set_rate = sr; set_lvl = sv;
    swing = sw; preemph = pe; start = 1'b1;
    x.tag = tag; x.amp = '0; x.scl = '0; x.emp = '0;
    x.err = !(lc == 1 || lc == 2 || lc == 4) || (sr && rc > 1);
    for (int l = 0; l < 4; l++)
      if (sv && l < lc && (int'(sw[2*l+:2]) + int'(pe[2*l+:2])) > 3) x.err = 1;
    if (!x.err && sv)
      for (int l = 0; l < lc; l++) begin
        lut(int'(sw[2*l+:2]), int'(pe[2*l+:2]), a, e);
        x.amp[3*l+:3] = 3'(a);
        x.scl[2*l+:2] = 2'd1;
        x.emp[4*l+:4] = 4'(e);
      end
    q.push_back(x);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk("R1 unexpected done", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk({x.tag, " err"}, 32'(err), 32'(x.err));
        chk({x.tag, " amp"}, 32'(amp), 32'(x.amp));
        chk({x.tag, " scale"}, 32'(amp_scale), 32'(x.scl));
        chk({x.tag, " emph"}, 32'(emph), 32'(x.emp));
        last = x;
      end
    end
  end

  task automatic hold_check();
    chk("R1 done low when idle", 32'(done), 0);
    chk("R1 err held", 32'(err), 32'(last.err));
    chk("R1 amp held", 32'(amp), 32'(last.amp));
    chk("R1 emph held", 32'(emph), 32'(last.emp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 done reset", 32'(done), 0);
    chk("R11 err reset", 32'(err), 0);
    chk("R11 codes reset", 32'({amp, amp_scale, emph}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // lane fields: lane i at bits [2i+1:2i] of swing/preemph
    go("R5 swing0 row", 4, 0, 1, 1, 8'b00_00_00_00, 8'b11_10_01_00); idle(1);
    go("R6 swing1 row", 4, 1, 1, 1, 8'b00_01_01_01, 8'b00_10_01_00); idle(1);
    go("R7 swing2/3 row", 4, 0, 0, 1, 8'b01_11_10_10, 8'b00_00_01_00); idle(1);
    go("R8 scale per lane", 2, 0, 0, 1, 8'b00_00_01_11, 8'b00_00_00_00); idle(1);
    go("R4 R9 inactive lanes ignored", 2, 0, 0, 1, 8'b11_11_00_10, 8'b11_11_00_01); idle(2);
    hold_check();
    go("R4 lane0 over range", 1, 0, 0, 1, 8'b00_00_00_10, 8'b00_00_00_10); idle(1);
    go("R4 lane3 over range", 4, 0, 0, 1, 8'b10_00_00_00, 8'b10_00_00_00); idle(1);
    go("R2 count 3", 3, 0, 0, 1, 8'h00, 8'h00); idle(1);
    go("R2 count 0", 0, 0, 0, 0, 8'h00, 8'h00); idle(1);
    go("R2 count 5", 5, 0, 0, 1, 8'h00, 8'h00); idle(1);
    go("R3 rate 2", 1, 2, 1, 1, 8'h00, 8'h00); idle(1);
    go("R3 rate 3", 1, 3, 1, 0, 8'h00, 8'h00); idle(1);
    go("R3 rate ignored", 1, 3, 0, 1, 8'h03, 8'h00); idle(1);
    go("R9 levels not requested", 4, 0, 1, 0, 8'h55, 8'h00); idle(1);
    go("R1 back to back a", 1, 0, 0, 1, 8'h00, 8'h03);
    go("R1 back to back b", 4, 0, 0, 1, 8'b11_10_01_00, 8'b00_00_01_10);
    go("R10 back to back err", 2, 0, 0, 1, 8'h0f, 8'h0f); idle(3);
    hold_check();
    chk("R1 all results seen", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule